// File: doc/BRIEF.md
# PLL Control and Lock-Interrupt Register Block

This block holds the software-visible control state of a clock generator's phase-locked loop. It keeps the loop enable, the output clock source choice, the interrupt enable, an automatic-mode switch and a 4-bit VCO range multiplier. It applies the cross-field protection rules among them, so that software cannot leave the loop in a state it cannot lock from.

The analog loop provides a lock indication. This signal is asynchronous, so the block synchronizes it and turns each transition into a flag. The flag is raised on both entry into lock and exit from lock, but only while automatic mode is on. Together with the interrupt enable, the flag drives a CPU interrupt request. Software reads the synchronized lock status to learn which way the loop moved. It then selects the VCO-derived clock (VCO divided by two) as the output source only once lock holds.

Access is through a simple synchronous read/write port with three registers. The control register is at address 0, the mode register at address 1 and the range register at address 2. The loop enable, the source select and the range are brought out as ports for the analog block and the clock multiplexer.

Top module: `pll_ctl`

## Requirements
- R1: After a synchronous reset, the range reads 6 at address 2 bits [3:0]. Loop enable, source select, interrupt enable, automatic mode and the flag are all 0, and `irq` is 0.
- R2: A write to the range register is ignored while the loop enable is 1.
- R3: A write to the range register takes effect on the next clock edge while the loop enable is 0.
- R4: A control-register write that sets the source select (bit 1) or the loop enable (bit 0) is refused while the range is zero.
- R5: Writing zero to the range clears the source select and keeps the loop disabled.
- R6: With automatic mode on (address 1 bit 0), every change of `lock_async` sets the flag. This covers rising and falling changes. The flag becomes visible on the third rising clock edge after the input changes, and not on the second.
- R7: The flag is set whether or not the interrupt enable (control bit 2) is set. `irq` equals the flag ANDed with the interrupt enable. The flag reads at control bit 3.
- R8: With automatic mode off, the flag reads 0 and `irq` is 0 at once. Lock changes set no flag.
- R9: A read of the control register clears the flag. If a lock transition arrives in the same cycle as that read, the flag stays set.
- R10: Control bit 4 reads the synchronized lock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read of address 0 clears the flag) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| lock_async | input | 1 | Lock indication from the analog loop, asynchronous |
| pll_en | output | 1 | Loop enable to the analog block |
| clk_sel | output | 1 | 1 selects VCO/2 as the output clock source |
| range_val | output | 4 | VCO range multiplier |
| irq | output | 1 | Interrupt request |

## Verification
A wrong protection decision shows on `pll_en`, `clk_sel` or `range_val` at the first sample after the offending write, because each field is a single register stage from the bus. A fault in the flag path shows on `irq` and on control bit 3. The bench samples it exactly two and three edges after a lock change, so an extra or missing synchronizer stage is caught as a one-cycle shift. A wrong clear-versus-set priority leaves `irq` low right after a read that collided with a transition.

// File: rtl/pll_ctl.sv
module pll_ctl #(
  parameter int DW      = 8,
  parameter int AW      = 2,
  parameter int RNG_W   = 4,
  parameter int RNG_RST = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             lock_async,
  output logic             pll_en,
  output logic             clk_sel,
  output logic [RNG_W-1:0] range_val,
  output logic             irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_MODE = AW'(1);
  localparam logic [AW-1:0] A_RNG  = AW'(2);

  logic             on_q, src_q, ie_q, auto_q, flag_q;
  logic [RNG_W-1:0] rng_q;
  logic             lk_s1, lk_s2, lk_d;

  wire lk_edge  = lk_s2 ^ lk_d;
  wire rng_nz   = |rng_q;
  wire ctrl_wr  = wr_en && addr == A_CTRL;
  wire rng_wr   = wr_en && addr == A_RNG && !on_q;
  wire flag_vis = flag_q && auto_q;
  wire ctrl_rd  = rd_en && addr == A_CTRL;

  logic unused_wbits;
  assign unused_wbits = ^wdata[DW-1:RNG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      {lk_s1, lk_s2, lk_d} <= '0;
      {on_q, src_q, ie_q, auto_q, flag_q} <= '0;
      rng_q <= RNG_W'(RNG_RST);
    end else begin
      lk_s1 <= lock_async;
      lk_s2 <= lk_s1;
      lk_d  <= lk_s2;
      if (wr_en && addr == A_MODE) auto_q <= wdata[0];
      if (ctrl_wr) begin
        ie_q  <= wdata[2];
        on_q  <= wdata[0] && rng_nz;
        src_q <= wdata[1] && rng_nz;
      end
      if (rng_wr) begin
        rng_q <= wdata[RNG_W-1:0];
        if (wdata[RNG_W-1:0] == '0) begin
          on_q  <= 1'b0;
          src_q <= 1'b0;
        end
      end
      if (!auto_q)      flag_q <= 1'b0;
      else if (lk_edge) flag_q <= 1'b1;
      else if (ctrl_rd) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {{(DW-5){1'b0}}, lk_s2, flag_vis, ie_q, src_q, on_q};
      A_MODE:  rdata = {{(DW-1){1'b0}}, auto_q};
      A_RNG:   rdata = {{(DW-RNG_W){1'b0}}, rng_q};
      default: rdata = '0;
    endcase
  end

  assign pll_en    = on_q;
  assign clk_sel   = src_q;
  assign range_val = rng_q;
  assign irq       = flag_vis && ie_q;

  AST_RANGE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (on_q && wr_en && addr == A_RNG) |=> $stable(rng_q)); // R2
  AST_ZERO_RANGE_OFF: assert property (@(posedge clk) disable iff (rst)
    (rng_q == '0) |-> (!on_q && !src_q)); // R5
  AST_FLAG_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (auto_q && lk_edge) |=> flag_q); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ie_q && auto_q)); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd && !lk_edge) |=> !flag_q); // R9
endmodule

// File: tb/tb_pll_ctl.sv
module tb_pll_ctl;
  logic       clk = 0, rst = 1, wr_en = 0, rd_en = 0, lock_async = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       pll_en, clk_sel, irq;
  logic [3:0] range_val;
  int total = 0, bad = 0;
  logic done = 0;

  pll_ctl dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
               .wdata(wdata), .rdata(rdata), .lock_async(lock_async),
               .pll_en(pll_en), .clk_sel(clk_sel), .range_val(range_val), .irq(irq));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic toggle_lock();
    @(negedge clk); lock_async = ~lock_async;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2, d); chk("R1 range", d, 6);
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 mode", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pll_en", pll_en, 0);
  endtask

  task automatic t_range();
    wr(0, 8'h01); chk("R3 pll_en on", pll_en, 1);
    wr(2, 8'h09); chk("R2 range locked", range_val, 6);
    wr(0, 8'h00); wr(2, 8'h09); chk("R3 range written", range_val, 9);
  endtask

  task automatic t_zero();
    wr(0, 8'h02); chk("R3 src set", clk_sel, 1);
    wr(2, 8'h00); chk("R5 src cleared", clk_sel, 0);
    chk("R5 range zero", range_val, 0);
    wr(0, 8'h03);
    chk("R4 src refused", clk_sel, 0);
    chk("R4 pll refused", pll_en, 0);
    wr(2, 8'h05); wr(0, 8'h03);
    chk("R4 src accepted", clk_sel, 1);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    wr(0, 8'h00); wr(2, 8'h07); wr(1, 8'h01); wr(0, 8'h05);
    @(negedge clk); lock_async = 1;
    repeat (2) @(negedge clk); chk("R6 not yet", irq, 0);
    @(negedge clk); chk("R6 rise flag", irq, 1);
    rd(0, d); chk("R10 lock high", d[4], 1); chk("R7 flag bit", d[3], 1);
    chk("R9 read clears", irq, 0);
    toggle_lock(); chk("R6 fall flag", irq, 1);
    rd(0, d); chk("R10 lock low", d[4], 0);
    chk("R9 clear after fall", irq, 0);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    wr(0, 8'h01);
    toggle_lock(); chk("R7 irq gated", irq, 0);
    rd(0, d); chk("R7 flag set without enable", d[3], 1);
    rd(0, d); chk("R9 flag cleared", d[3], 0);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    wr(0, 8'h05);
    toggle_lock(); chk("R9 pre flag", irq, 1);
    @(negedge clk); lock_async = ~lock_async;
    repeat (2) @(negedge clk);
    rd_en = 1; addr = 0;
    @(negedge clk); rd_en = 0;
    chk("R9 transition wins", irq, 1);
    rd(0, d); chk("R9 later clear", irq, 0);
  endtask

  task automatic t_manual();
    logic [7:0] d;
    toggle_lock(); chk("R8 flag pre", irq, 1);
    @(negedge clk); wr_en = 1; addr = 1; wdata = 0;
    @(negedge clk); wr_en = 0;
    chk("R8 irq drops", irq, 0);
    toggle_lock(); chk("R8 no irq", irq, 0);
    rd(0, d); chk("R8 flag reads 0", d[3], 0);
    wr(1, 8'h01); @(negedge clk);
    chk("R8 flag gone after re-enable", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_range(); t_zero(); t_lock(); t_gate(); t_prio(); t_manual();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule